// File: doc/BRIEF.md
# Channel trigger timing sequencer

This block steps each detector channel of a card through the timing of one event. A rising edge on a channel's constant-fraction discriminator input starts a step counter for that channel. Each clock cycle is one 10 ns step, and the counter is 10 bits wide, so a sequence lasts at most about 10 µs. Four compare points mark the end of the fast-trigger window, the end of the validation window, the conversion start, and the readout start. They are programmed once and shared by every channel. While a sequence runs, the block tells the peak detector to track or to hold. It waits for the card-wide validation and drops the event if the validation is late. It pulses conversion and readout, and it marks an event as piled up when a second discriminator edge arrives before the readout point.

Each discriminator input is also echoed, one cycle later, for external anti-Compton logic. Forming the global trigger is handled elsewhere.

Top module: `tts_seq_top`

## Requirements
- R1: After reset every output is low: `ftw_o`, `trk_o`, `hold_o`, `cnv_o`, `rd_o`, `pu_o` and `cfd_o`.
- R2: An idle channel starts a sequence when its `cfd_i` is low in one cycle and high in the next. Step 0 is the first cycle after that edge, and the count rises by one each cycle. `ftw_o` is high at steps 0 up to `pt_ftw_i`-1, which is `pt_ftw_i` cycles; when `pt_ftw_i` is 0 it stays low.
- R3: `trk_o` is high at steps 0 up to `pt_cnv_i`-2. `hold_o` is high from step `pt_cnv_i`-1 through step `pt_rd_i`. The two are never high together.
- R4: `cnv_o` is high for exactly one cycle, at step `pt_cnv_i`, and `hold_o` is already high in the cycle before it.
- R5: `rd_o` is high for exactly one cycle, at step `pt_rd_i`. The sequence then ends, so `trk_o` and `hold_o` are low in the next cycle.
- R6: The event is validated if `val_i` is high in any cycle at steps 0 to `pt_vwe_i`. If it is not, the sequence aborts after step `pt_vwe_i`: `hold_o`, `cnv_o` and `rd_o` never go high for that event, and all channel outputs are low from the next cycle.
- R7: A `cfd_i` rising edge during a running sequence, at any step before `pt_rd_i`, raises `pu_o` from the following step until the sequence ends. The counter keeps running and is not restarted. An edge at step `pt_rd_i` is ignored. `pu_o` is cleared when the next sequence starts.
- R8: `cfd_o` of every channel equals that channel's `cfd_i` delayed by one cycle, whatever the sequence state.
- R9: A sequence starts only when the compare points are ordered as follows: `pt_ftw_i` <= `pt_vwe_i`, `pt_vwe_i`+2 <= `pt_cnv_i`, and `pt_cnv_i` < `pt_rd_i`. If they are not, discriminator edges start nothing.
- R10: Channels run independently. Activity on one channel leaves the sequence outputs of the others unchanged, and all channels share the compare points and `val_i`.
- R11: A `cfd_i` held high starts one sequence only and raises no pileup; a new start needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfd_i | input | NUM_CH | Discriminator input, one bit per channel |
| val_i | input | 1 | Card-wide validation |
| pt_ftw_i | input | CNT_W | Step at which the fast-trigger window ends |
| pt_vwe_i | input | CNT_W | Step at which the validation window ends |
| pt_cnv_i | input | CNT_W | Conversion start step |
| pt_rd_i | input | CNT_W | Readout start step |
| ftw_o | output | NUM_CH | Fast-trigger window open |
| trk_o | output | NUM_CH | Peak detector tracking |
| hold_o | output | NUM_CH | Peak detector holding |
| cnv_o | output | NUM_CH | Conversion start pulse |
| rd_o | output | NUM_CH | Readout start pulse |
| pu_o | output | NUM_CH | Pileup qualifier of the current event |
| cfd_o | output | NUM_CH | Discriminator echo for anti-Compton logic |

## Verification
Some properties are checked on every cycle:
- track and hold are never high together, and hold leads each conversion pulse;
- each readout pulse is single and ends the sequence;
- pileup rises only after a fresh discriminator edge;
- the discriminator echo is exact;
- a misordered set of compare points never starts a sequence.

The exact steps at which each output rises and falls, the abort when validation comes one step late, and a pileup edge at the readout step being ignored can only be shown by the bench. It sweeps small sets of compare points and computes the expected waveform step by step. Its scenarios also show that two overlapping channels do not disturb each other, and that a level held high starts only one sequence.

// File: rtl/tts_pkg.sv
package tts_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/tts_order_chk.sv
module tts_order_chk #(
  parameter int unsigned CNT_W = 10
) (
  input  logic [CNT_W-1:0] pt_ftw_i,
  input  logic [CNT_W-1:0] pt_vwe_i,
  input  logic [CNT_W-1:0] pt_cnv_i,
  input  logic [CNT_W-1:0] pt_rd_i,
  output logic             cfg_ok_o
);
  localparam int unsigned EW = CNT_W + 1;

  logic [EW-1:0] vwe_gap;

  // Two steps of margin: hold starts one step before conversion,
  // and it must follow the validation decision.
  assign vwe_gap  = {1'b0, pt_vwe_i} + EW'(2);
  assign cfg_ok_o = (pt_ftw_i <= pt_vwe_i) &&
                    (vwe_gap <= {1'b0, pt_cnv_i}) &&
                    (pt_cnv_i < pt_rd_i);
endmodule

// File: rtl/tts_chan_seq.sv
module tts_chan_seq
  import tts_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ok_i,
  input  logic             cfd_i,
  input  logic             val_i,
  input  logic [CNT_W-1:0] pt_ftw_i,
  input  logic [CNT_W-1:0] pt_vwe_i,
  input  logic [CNT_W-1:0] pt_cnv_i,
  input  logic [CNT_W-1:0] pt_rd_i,
  output logic             ftw_o,
  output logic             trk_o,
  output logic             hold_o,
  output logic             cnv_o,
  output logic             rd_o,
  output logic             pu_o,
  output logic             cfd_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             vld_q;
  logic             pu_q;
  logic             cfd_q;

  logic             cfd_edge;
  logic             run;
  logic             at_vwe;
  logic             at_rd;
  logic             cnt_max;
  logic             abort;
  logic [CNT_W-1:0] hold_pt;

  assign cfd_edge = cfd_i & ~cfd_q;
  assign run      = (st_q == SEQ_RUN);
  assign at_vwe   = (cnt_q == pt_vwe_i);
  assign at_rd    = (cnt_q == pt_rd_i);
  assign cnt_max  = &cnt_q;
  assign abort    = at_vwe && !(vld_q || val_i);
  assign hold_pt  = pt_cnv_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      vld_q <= 1'b0;
      pu_q  <= 1'b0;
      cfd_q <= 1'b0;
    end else begin
      cfd_q <= cfd_i;
      unique case (st_q)
        SEQ_IDLE: begin
          if (cfd_edge && cfg_ok_i) begin
            st_q  <= SEQ_RUN;
            cnt_q <= '0;
            vld_q <= 1'b0;
            pu_q  <= 1'b0;
          end
        end
        SEQ_RUN: begin
          if (val_i && (cnt_q <= pt_vwe_i)) vld_q <= 1'b1;
          if (cfd_edge) pu_q <= 1'b1;
          if (abort || at_rd || cnt_max) begin
            st_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ftw_o  = run && (cnt_q < pt_ftw_i);
    trk_o  = run && (cnt_q < hold_pt);
    hold_o = run && (cnt_q >= hold_pt);
    cnv_o  = run && (cnt_q == pt_cnv_i);
    rd_o   = run && at_rd;
    pu_o   = run && pu_q;
    cfd_o  = cfd_q;
  end
endmodule

// File: rtl/tts_seq_top.sv
module tts_seq_top #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cfd_i,
  input  logic              val_i,
  input  logic [CNT_W-1:0]  pt_ftw_i,
  input  logic [CNT_W-1:0]  pt_vwe_i,
  input  logic [CNT_W-1:0]  pt_cnv_i,
  input  logic [CNT_W-1:0]  pt_rd_i,
  output logic [NUM_CH-1:0] ftw_o,
  output logic [NUM_CH-1:0] trk_o,
  output logic [NUM_CH-1:0] hold_o,
  output logic [NUM_CH-1:0] cnv_o,
  output logic [NUM_CH-1:0] rd_o,
  output logic [NUM_CH-1:0] pu_o,
  output logic [NUM_CH-1:0] cfd_o
);
  logic cfg_ok;

  tts_order_chk #(.CNT_W(CNT_W)) u_order (
    .pt_ftw_i (pt_ftw_i),
    .pt_vwe_i (pt_vwe_i),
    .pt_cnv_i (pt_cnv_i),
    .pt_rd_i  (pt_rd_i),
    .cfg_ok_o (cfg_ok)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tts_chan_seq #(.CNT_W(CNT_W)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_ok_i (cfg_ok),
      .cfd_i    (cfd_i[g]),
      .val_i    (val_i),
      .pt_ftw_i (pt_ftw_i),
      .pt_vwe_i (pt_vwe_i),
      .pt_cnv_i (pt_cnv_i),
      .pt_rd_i  (pt_rd_i),
      .ftw_o    (ftw_o[g]),
      .trk_o    (trk_o[g]),
      .hold_o   (hold_o[g]),
      .cnv_o    (cnv_o[g]),
      .rd_o     (rd_o[g]),
      .pu_o     (pu_o[g]),
      .cfd_o    (cfd_o[g])
    );
  end
endmodule

// File: rtl/tts_seq_chk.sv
module tts_seq_chk #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] cfd_i,
  input logic [CNT_W-1:0]  pt_ftw_i,
  input logic [CNT_W-1:0]  pt_vwe_i,
  input logic [CNT_W-1:0]  pt_cnv_i,
  input logic [CNT_W-1:0]  pt_rd_i,
  input logic [NUM_CH-1:0] ftw_o,
  input logic [NUM_CH-1:0] trk_o,
  input logic [NUM_CH-1:0] hold_o,
  input logic [NUM_CH-1:0] cnv_o,
  input logic [NUM_CH-1:0] rd_o,
  input logic [NUM_CH-1:0] pu_o,
  input logic [NUM_CH-1:0] cfd_o
);
  logic bad_cfg;
  assign bad_cfg = (pt_ftw_i > pt_vwe_i) ||
                   ({1'b0, pt_vwe_i} + (CNT_W+1)'(2) > {1'b0, pt_cnv_i}) ||
                   (pt_cnv_i >= pt_rd_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_ftw_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(trk_o[g]) && (pt_ftw_i != '0)) |-> ftw_o[g]);

    p_trk_hold_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(trk_o[g] && hold_o[g]));

    p_hold_leads_cnv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnv_o[g] |-> (hold_o[g] && $past(hold_o[g])));

    p_rd_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_o[g] |=> (!rd_o[g] && !trk_o[g] && !hold_o[g]));

    p_pu_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pu_o[g]) |-> $past(cfd_i[g] && !cfd_o[g]));

    p_cfd_echo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (cfd_o[g] == $past(cfd_i[g])));

    p_bad_cfg_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bad_cfg && !trk_o[g] && !hold_o[g]) |=> (!trk_o[g] && !hold_o[g]));
  end
endmodule

bind tts_seq_top tts_seq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfd_i    (cfd_i),
  .pt_ftw_i (pt_ftw_i),
  .pt_vwe_i (pt_vwe_i),
  .pt_cnv_i (pt_cnv_i),
  .pt_rd_i  (pt_rd_i),
  .ftw_o    (ftw_o),
  .trk_o    (trk_o),
  .hold_o   (hold_o),
  .cnv_o    (cnv_o),
  .rd_o     (rd_o),
  .pu_o     (pu_o),
  .cfd_o    (cfd_o)
);

// File: tb/sim_tts_seq_top.sv
`timescale 1ns/1ps
module sim_tts_seq_top;
  localparam int NCH = 5;
  localparam int CW  = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] cfd;
  logic           val;
  logic [CW-1:0]  p_ftw, p_vwe, p_cnv, p_rd;
  logic [NCH-1:0] ftw, trk, hold, cnv, rd, pu, cfdo;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  tts_seq_top #(.NUM_CH(NCH), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfd_i(cfd), .val_i(val),
    .pt_ftw_i(p_ftw), .pt_vwe_i(p_vwe), .pt_cnv_i(p_cnv), .pt_rd_i(p_rd),
    .ftw_o(ftw), .trk_o(trk), .hold_o(hold), .cnv_o(cnv), .rd_o(rd),
    .pu_o(pu), .cfd_o(cfdo)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // {ftw, trk, hold, cnv, rd, pu} expected at step s; vs = validation step, ps = pileup edge step
  function automatic logic [5:0] exp_bits(int s, int f, int v, int c, int r, int vs, int ps);
    bit ok    = (vs >= 0) && (vs <= v);
    bit alive = (s >= 0) && (ok ? (s <= r) : (s <= v));
    return {alive && (s < f), alive && (s <= c - 2), alive && (s >= c - 1),
            alive && (s == c), alive && (s == r),
            alive && (ps >= 0) && (ps < r) && (s > ps)};
  endfunction

  task automatic check_one(int ch, int s, logic [5:0] e, bit cfd_e, string stag);
    string ftag[6] = '{"R2 ftw", "R3 trk", "R3 hold", "R4 cnv", "R5 rd", "R7 pu"};
    logic [5:0] got = {ftw[ch], trk[ch], hold[ch], cnv[ch], rd[ch], pu[ch]};
    for (int i = 0; i < 6; i++)
      chk(got[5-i] === e[5-i], $sformatf("%s/%s ch%0d step%0d", ftag[i], stag, ch, s),
          int'(got[5-i]), int'(e[5-i]));
    chk(cfdo[ch] === cfd_e, $sformatf("R8 cfd_o/%s ch%0d step%0d", stag, ch, s),
        int'(cfdo[ch]), int'(cfd_e));
  endtask

  task automatic check_quiet(int k, string tag);
    logic [6:0] got = {ftw[k], trk[k], hold[k], cnv[k], rd[k], pu[k], cfdo[k]};
    chk(got === 7'd0, $sformatf("%s quiet ch%0d", tag, k), int'(got), 0);
  endtask

  task automatic set_pts(int f, int v, int c, int r);
    p_ftw = CW'(f); p_vwe = CW'(v); p_cnv = CW'(c); p_rd = CW'(r);
  endtask

  task automatic run_seq(int ch, int f, int v, int c, int r, int vs, int ps, string stag);
    @(negedge clk);
    set_pts(f, v, c, r);
    cfd[ch] = 1'b1; val = 1'b0;
    @(posedge clk);
    for (int s = 0; s <= r + 2; s++) begin
      @(negedge clk);
      check_one(ch, s, exp_bits(s, f, v, c, r, vs, ps), (s == 0) || (s - 1 == ps), stag);
      for (int k = 0; k < NCH; k++) if (k != ch) check_quiet(k, "R10");
      val     = (s == vs);
      cfd[ch] = (s == ps);
    end
    cfd[ch] = 1'b0; val = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n = 0;
    cfd = '0; val = 1'b0; set_pts(1, 2, 4, 6);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) check_quiet(k, "R1");

    // Sweep of small ordered configurations
    for (int c = 3; c <= 6; c++)
      for (int r = c + 1; r <= c + 2; r++)
        for (int f = 0; f <= 2; f++)
          for (int v = f; v <= c - 2; v++)
            for (int m = 0; m < 4; m++) begin
              int ch = n % NCH;
              n++;
              case (m)
                0: run_seq(ch, f, v, c, r, 0, -1, "main");
                1: run_seq(ch, f, v, c, r, v, -1, "R6 late-ok");
                2: run_seq(ch, f, v, c, r, v + 1, -1, "R6 abort");
                default: run_seq(ch, f, v, c, r, v, 1 + (n % r), "R7 pileup");
              endcase
            end

    // R10: two overlapping channels, ch1 starts two steps after ch0
    @(negedge clk);
    set_pts(1, 4, 7, 9);
    cfd[0] = 1'b1; val = 1'b0;
    @(posedge clk);
    for (int t = 0; t <= 13; t++) begin
      @(negedge clk);
      check_one(0, t, exp_bits(t, 1, 4, 7, 9, 2, -1), t == 0, "R10 a");
      check_one(1, t - 2, exp_bits(t - 2, 1, 4, 7, 9, 0, -1), t == 2, "R10 b");
      for (int k = 2; k < NCH; k++) check_quiet(k, "R10");
      cfd[0] = 1'b0;
      cfd[1] = (t == 1);
      val    = (t == 2);
    end
    cfd = '0; val = 1'b0;
    repeat (2) @(negedge clk);

    // R11: level held high starts one sequence, no pileup, no restart
    @(negedge clk);
    set_pts(1, 2, 4, 5);
    cfd[2] = 1'b1;
    @(posedge clk);
    for (int s = 0; s <= 11; s++) begin
      @(negedge clk);
      check_one(2, s, exp_bits(s, 1, 2, 4, 5, 0, -1), 1'b1, "R11");
      val = (s == 0);
    end
    cfd[2] = 1'b0; val = 1'b0;
    repeat (2) @(negedge clk);

    // R9: misordered compare points start nothing
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      case (b)
        0: set_pts(3, 2, 6, 8);
        1: set_pts(0, 3, 4, 6);
        default: set_pts(0, 1, 5, 5);
      endcase
      cfd[1] = 1'b1; val = 1'b1;
      @(posedge clk);
      for (int s = 0; s <= 9; s++) begin
        @(negedge clk);
        check_one(1, s, 6'd0, s == 0, "R9");
        cfd[1] = 1'b0;
      end
      val = 1'b0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule